// File: doc/BRIEF.md
# External Memory Bus Controller with Sectored Wait States

This block sits between a processor's data-space port and an external multiplexed memory bus. When the bus is enabled, any data-space access whose address lies above the top of the internal SRAM is claimed. The processor is held in a stall while the block runs one full bus transaction. A transaction has three parts. First comes a one-cycle address phase, in which the low address byte is placed on the shared data lines with a latch-enable pulse and the high address bits are driven on their own lines. Next comes an active-low read or write strobe, stretched by a programmable number of wait cycles. The last part is an optional address-hold cycle.

The external address space is split into a lower and an upper sector. A configuration field sets the boundary between them, and each sector has its own 2-bit wait setting. A second field releases some of the high address lines, counting down from the top bit, so those pins can serve other uses. An optional bus keeper holds the last value driven on the data lines whenever the block is not driving them. The configuration values arrive as input ports. Multiplexing these pins with general-purpose ports is left to the surrounding logic.

Top module: `xmem_bus_ctrl`

## Requirements
- R1: An access is claimed (stall raised, bus cycle started) only when `cfg_en` is 1 and `cpu_addr` is strictly greater than `INT_TOP` (default 0x025F). Any other request leaves `cpu_stall` at 0 and the bus idle.
- R2: Each claimed access begins with exactly one address cycle before any strobe. In that cycle `bus_ale`=1, `bus_ad_oe`=1, `bus_ad_out`=address bits [7:0], and both strobes are high.
- R3: Let s be the selected 2-bit wait setting. The strobe is low for 1 cycle when s=0, 2 cycles when s=1, and 3 cycles when s=2 or s=3. When s=3 only, one more cycle follows the strobe with both strobes high and the address still held.
- R4: If `cfg_sec` is 0, the lower setting `cfg_ws_lo` applies to every external address. Otherwise, an address whose bits [15:13] are less than `cfg_sec` uses `cfg_ws_lo`, and all other addresses use `cfg_ws_hi`.
- R5: `cpu_stall` is high from the accepting cycle through the last bus cycle, for 3 + min(s,2) + (s==3) cycles in total. It then drops for one completion cycle.
- R6: On a read, the data lines are released (`bus_ad_oe`=0) while `bus_rd_n` is low. `cpu_rdata` takes the `bus_ad_in` value present in the last strobe cycle and keeps it until the next read.
- R7: On a write, `bus_ad_oe`=1 and `bus_ad_out`=`cpu_wdata` during every cycle in which `bus_wr_n` is low.
- R8: `bus_rd_n` and `bus_wr_n` are never low together, and both are high when no access is in progress.
- R9: Let n = min(`cfg_hrel`, 8). Bit i of `bus_ah_oe` is 1 exactly when `cfg_en`=1 and i < 8-n. Driven lines carry address bits [15:8], and released lines output 0.
- R10: While `bus_ad_oe`=0 and `cfg_keep`=1, `bus_ad_hold`=1 and `bus_ad_out` keeps the last value driven. With `cfg_keep`=0, `bus_ad_hold`=0 and `bus_ad_out`=0 while not driving.
- R11: During reset, both strobes are high, and `bus_ale`, `bus_ad_oe`, `cpu_stall` and `cpu_rdata` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | External bus enable |
| cfg_ws_lo | input | 2 | Wait setting, lower sector |
| cfg_ws_hi | input | 2 | Wait setting, upper sector |
| cfg_sec | input | 3 | Sector boundary in units of 8 KiB; 0 = single sector |
| cfg_hrel | input | 4 | Number of high address lines released, from the top |
| cfg_keep | input | 1 | Bus keeper enable |
| cpu_req | input | 1 | Data-space access request, held while stalled |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | Access address |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data of the last external read |
| cpu_stall | output | 1 | Processor stall |
| bus_ale | output | 1 | Address latch enable |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_ad_out | output | 8 | Multiplexed address/data output |
| bus_ad_oe | output | 1 | Output enable of the data lines |
| bus_ad_in | input | 8 | Data lines as seen at the pads |
| bus_ad_hold | output | 1 | Keeper holding the data lines |
| bus_ah_out | output | 8 | High address lines |
| bus_ah_oe | output | 8 | Per-line enable of the high address lines |

## Verification
The bench sweeps every wait setting through both sectors. It includes a boundary value equal to an address's top bits, where an off-by-one in the sector compare would pick the wrong setting and change the strobe length. It probes the last internal address and the first external one, where a wrong comparison would stall on internal memory or miss an external access. Read data changes on each strobe cycle, so a design that sampled too early returns an earlier value. The bench also checks the release counts 0, 1, 3, 8 and 12 for a wrong shift or a missing clamp, and checks the keeper both on and off.

// File: rtl/xmb_pkg.sv
package xmb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_STRB,
    ST_HOLD,
    ST_DONE
  } xmb_state_e;

  // extra strobe cycles beyond the first for a 2-bit wait setting
  function automatic logic [1:0] strobe_extra(input logic [1:0] setting);
    return (setting == 2'd3) ? 2'd2 : setting;
  endfunction

  // only the top setting appends an address-hold cycle
  function automatic logic adds_hold(input logic [1:0] setting);
    return setting == 2'd3;
  endfunction

endpackage

// File: rtl/xmb_decode.sv
module xmb_decode #(
  parameter int ADDR_W  = 16,
  parameter int SEC_W   = 3,
  parameter int INT_TOP = 'h025F
) (
  input  logic              cfg_en,
  input  logic [1:0]        cfg_ws_lo,
  input  logic [1:0]        cfg_ws_hi,
  input  logic [SEC_W-1:0]  cfg_sec,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic              in_lower,
  output logic [1:0]        ws_sel
);

  localparam logic [ADDR_W-1:0] TOP_V = ADDR_W'(INT_TOP);

  function automatic logic sector_lower(input logic [SEC_W-1:0] region,
                                        input logic [SEC_W-1:0] limit);
    return (limit == '0) || (region < limit);
  endfunction

  assign hit      = cfg_en && (addr > TOP_V);
  assign in_lower = sector_lower(addr[ADDR_W-1 -: SEC_W], cfg_sec);
  assign ws_sel   = in_lower ? cfg_ws_lo : cfg_ws_hi;

endmodule

// File: rtl/xmb_seq.sv
module xmb_seq
  import xmb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              we_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] wdata_in,
  input  logic [1:0]        ws_sel,
  output xmb_state_e        state,
  output logic              we_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic              last_strb,
  output logic              busy
);

  logic [1:0] cnt;
  logic       hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      hold_q  <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state   <= ST_ADDR;
          we_q    <= we_in;
          addr_q  <= addr_in;
          wdata_q <= wdata_in;
          cnt     <= strobe_extra(ws_sel);
          hold_q  <= adds_hold(ws_sel);
        end
        ST_ADDR: state <= ST_STRB;
        ST_STRB: begin
          if (cnt == 2'd0) state <= hold_q ? ST_HOLD : ST_DONE;
          else             cnt   <= cnt - 2'd1;
        end
        ST_HOLD: state <= ST_DONE;
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign last_strb = (state == ST_STRB) && (cnt == 2'd0);
  assign busy      = (state == ST_ADDR) || (state == ST_STRB) || (state == ST_HOLD);

endmodule

// File: rtl/xmb_pins.sv
module xmb_pins
  import xmb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int HI_W   = ADDR_W - DATA_W,
  parameter int REL_W  = $clog2(HI_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  xmb_state_e        state,
  input  logic              we_q,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic [DATA_W-1:0] wdata_q,
  input  logic              cfg_en,
  input  logic [REL_W-1:0]  cfg_hrel,
  input  logic              cfg_keep,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic              ad_hold,
  output logic [HI_W-1:0]   ah_out,
  output logic [HI_W-1:0]   ah_oe
);

  logic [DATA_W-1:0] drv_val;
  logic [DATA_W-1:0] last_ad;
  logic [HI_W-1:0]   line_kept;
  logic              strobing;

  function automatic logic [HI_W-1:0] drive_mask(input logic [REL_W-1:0] rel);
    logic [REL_W-1:0] lim;
    logic [HI_W-1:0]  m;
    lim = (rel > REL_W'(HI_W)) ? REL_W'(HI_W) : rel;
    for (int i = 0; i < HI_W; i++) m[i] = REL_W'(i) < (REL_W'(HI_W) - lim);
    return m;
  endfunction

  assign strobing = (state == ST_STRB);
  assign ale      = (state == ST_ADDR);
  assign rd_n     = !(strobing && !we_q);
  assign wr_n     = !(strobing && we_q);
  assign ad_oe    = ale || (we_q && (strobing || state == ST_HOLD));
  assign drv_val  = ale ? addr_q[DATA_W-1:0] : wdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     last_ad <= '0;
    else if (ad_oe) last_ad <= drv_val;
  end

  assign ad_hold = cfg_keep && !ad_oe;
  assign ad_out  = ad_oe ? drv_val : (cfg_keep ? last_ad : '0);

  assign line_kept = drive_mask(cfg_hrel);

  for (genvar g = 0; g < HI_W; g++) begin : g_hi
    assign ah_oe[g]  = cfg_en && line_kept[g];
    assign ah_out[g] = ah_oe[g] && addr_q[DATA_W + g];
  end

endmodule

// File: rtl/xmem_bus_ctrl.sv
module xmem_bus_ctrl
  import xmb_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int SEC_W   = 3,
  parameter int INT_TOP = 'h025F
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  cfg_en,
  input  logic [1:0]                            cfg_ws_lo,
  input  logic [1:0]                            cfg_ws_hi,
  input  logic [SEC_W-1:0]                      cfg_sec,
  input  logic [$clog2(ADDR_W-DATA_W+1)-1:0]    cfg_hrel,
  input  logic                                  cfg_keep,
  input  logic                                  cpu_req,
  input  logic                                  cpu_we,
  input  logic [ADDR_W-1:0]                     cpu_addr,
  input  logic [DATA_W-1:0]                     cpu_wdata,
  output logic [DATA_W-1:0]                     cpu_rdata,
  output logic                                  cpu_stall,
  output logic                                  bus_ale,
  output logic                                  bus_rd_n,
  output logic                                  bus_wr_n,
  output logic [DATA_W-1:0]                     bus_ad_out,
  output logic                                  bus_ad_oe,
  input  logic [DATA_W-1:0]                     bus_ad_in,
  output logic                                  bus_ad_hold,
  output logic [ADDR_W-DATA_W-1:0]              bus_ah_out,
  output logic [ADDR_W-DATA_W-1:0]              bus_ah_oe
);

  localparam int HI_W  = ADDR_W - DATA_W;
  localparam int REL_W = $clog2(HI_W + 1);

  logic              dec_hit;
  logic              dec_lower;
  logic [1:0]        dec_ws;
  logic              acc_start;
  logic              seq_busy;
  logic              seq_last_strb;
  logic              rd_sample;
  xmb_state_e        seq_state;
  logic              seq_we;
  logic [ADDR_W-1:0] seq_addr;
  logic [DATA_W-1:0] seq_wdata;

  xmb_decode #(.ADDR_W(ADDR_W), .SEC_W(SEC_W), .INT_TOP(INT_TOP)) u_dec (
    .cfg_en   (cfg_en),
    .cfg_ws_lo(cfg_ws_lo),
    .cfg_ws_hi(cfg_ws_hi),
    .cfg_sec  (cfg_sec),
    .addr     (cpu_addr),
    .hit      (dec_hit),
    .in_lower (dec_lower),
    .ws_sel   (dec_ws)
  );

  assign acc_start = cpu_req && dec_hit && (seq_state == ST_IDLE);

  xmb_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (acc_start),
    .we_in    (cpu_we),
    .addr_in  (cpu_addr),
    .wdata_in (cpu_wdata),
    .ws_sel   (dec_ws),
    .state    (seq_state),
    .we_q     (seq_we),
    .addr_q   (seq_addr),
    .wdata_q  (seq_wdata),
    .last_strb(seq_last_strb),
    .busy     (seq_busy)
  );

  xmb_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .HI_W(HI_W), .REL_W(REL_W)) u_pins (
    .clk     (clk),
    .rst_n   (rst_n),
    .state   (seq_state),
    .we_q    (seq_we),
    .addr_q  (seq_addr),
    .wdata_q (seq_wdata),
    .cfg_en  (cfg_en),
    .cfg_hrel(cfg_hrel),
    .cfg_keep(cfg_keep),
    .ale     (bus_ale),
    .rd_n    (bus_rd_n),
    .wr_n    (bus_wr_n),
    .ad_out  (bus_ad_out),
    .ad_oe   (bus_ad_oe),
    .ad_hold (bus_ad_hold),
    .ah_out  (bus_ah_out),
    .ah_oe   (bus_ah_oe)
  );

  assign rd_sample = seq_last_strb && !seq_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cpu_rdata <= '0;
    else if (rd_sample) cpu_rdata <= bus_ad_in;
  end

  assign cpu_stall = acc_start || seq_busy;

endmodule

// File: rtl/xmem_bus_ctrl_chk.sv
module xmem_bus_ctrl_chk #(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int INT_TOP = 'h025F
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_en,
  input logic              cfg_keep,
  input logic              cpu_req,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_stall,
  input logic              seq_busy,
  input logic              bus_ale,
  input logic              bus_rd_n,
  input logic              bus_wr_n,
  input logic              bus_ad_oe,
  input logic [DATA_W-1:0] bus_ad_out
);

  AST_STRB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_rd_n && !bus_wr_n)); // R8
  AST_ALE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ale |-> (bus_rd_n && bus_wr_n && bus_ad_oe)); // R2
  AST_RD_AFTER_ALE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_rd_n) |-> $past(bus_ale)); // R2
  AST_WR_AFTER_ALE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_wr_n) |-> $past(bus_ale)); // R2
  AST_NO_CLAIM_INT: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !seq_busy && cpu_addr <= ADDR_W'(INT_TOP)) |-> !cpu_stall); // R1
  AST_NO_CLAIM_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !seq_busy && !cfg_en) |-> !cpu_stall); // R1
  AST_WR_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr_n |-> bus_ad_oe); // R7
  AST_RD_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_n |-> (!bus_ad_oe && cpu_stall)); // R6
  AST_KEEP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_ad_oe && cfg_keep && $past(cfg_keep) && $past(bus_ad_oe)) |-> bus_ad_out == $past(bus_ad_out)); // R10

endmodule

bind xmem_bus_ctrl xmem_bus_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .INT_TOP(INT_TOP)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_en    (cfg_en),
  .cfg_keep  (cfg_keep),
  .cpu_req   (cpu_req),
  .cpu_addr  (cpu_addr),
  .cpu_stall (cpu_stall),
  .seq_busy  (seq_busy),
  .bus_ale   (bus_ale),
  .bus_rd_n  (bus_rd_n),
  .bus_wr_n  (bus_wr_n),
  .bus_ad_oe (bus_ad_oe),
  .bus_ad_out(bus_ad_out)
);

// File: tb/xmem_bus_ctrl_test.sv
module xmem_bus_ctrl_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_en = 1'b0;
  logic [1:0] cfg_ws_lo = '0, cfg_ws_hi = '0;
  logic [2:0] cfg_sec = '0;
  logic [3:0] cfg_hrel = '0;
  logic       cfg_keep = 1'b0;
  logic       cpu_req = 1'b0, cpu_we = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0, bus_ad_in = '0;
  logic [7:0]  cpu_rdata, bus_ad_out, bus_ah_out, bus_ah_oe;
  logic        cpu_stall, bus_ale, bus_rd_n, bus_wr_n, bus_ad_oe, bus_ad_hold;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  bit done     = 1'b0;

  xmem_bus_ctrl uut (.*);

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !done) begin
      done = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: act %0d exp below 100000 cycles", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: act %0h exp %0h", tag, act, exp);
    end
  endtask

  // vector: we, addr, wdata, ws_lo, ws_hi, sec, hrel, keep
  localparam int NV = 8;
  localparam logic [36:0] VEC [NV] = '{
    {1'b0, 16'h0260, 8'h00, 2'd0, 2'd3, 3'd0, 4'd0,  1'b1},
    {1'b1, 16'h1234, 8'h5A, 2'd1, 2'd2, 3'd2, 4'd0,  1'b1},
    {1'b0, 16'h8ABC, 8'h00, 2'd1, 2'd2, 3'd2, 4'd3,  1'b0},
    {1'b1, 16'hE001, 8'hC3, 2'd0, 2'd3, 3'd7, 4'd8,  1'b1},
    {1'b0, 16'hC0F0, 8'h00, 2'd3, 2'd0, 3'd7, 4'd2,  1'b0},
    {1'b1, 16'h4000, 8'h81, 2'd2, 2'd0, 3'd2, 4'd12, 1'b1},
    {1'b0, 16'hFFFF, 8'h00, 2'd2, 2'd1, 3'd0, 4'd1,  1'b1},
    {1'b1, 16'h2000, 8'h7E, 2'd3, 2'd1, 3'd1, 4'd0,  1'b0}
  };

  // bench-side restatement of the sector and timing rules
  function automatic logic [1:0] pick_setting(input logic [15:0] a, input logic [1:0] lo,
                                              input logic [1:0] hi, input logic [2:0] sec);
    if (sec == 3'd0) return lo;
    return (a[15:13] >= sec) ? hi : lo;
  endfunction

  function automatic int strobe_len(input logic [1:0] s);
    case (s)
      2'd0: return 1;
      2'd1: return 2;
      default: return 3;
    endcase
  endfunction

  function automatic logic [7:0] exp_mask(input logic [3:0] rel);
    int n;
    n = (rel > 4'd8) ? 8 : int'(rel);
    return 8'hFF >> n;
  endfunction

  task automatic run_access(input logic [36:0] v);
    logic we; logic [15:0] a; logic [7:0] wd; logic [1:0] s;
    int n_stall, n_ale, n_strb, n_hold, k, len, hd;
    logic [7:0] base, ah_o, ah_e, ale_ad;
    logic ale_oe;
    we = v[36]; a = v[35:20]; wd = v[19:12];
    cfg_en = 1'b1; cfg_ws_lo = v[11:10]; cfg_ws_hi = v[9:8]; cfg_sec = v[7:5];
    cfg_hrel = v[4:1]; cfg_keep = v[0];
    s = pick_setting(a, v[11:10], v[9:8], v[7:5]);
    len = strobe_len(s); hd = (s == 2'd3) ? 1 : 0;
    base = a[7:0] ^ 8'h3C;
    n_stall = 0; n_ale = 0; n_strb = 0; n_hold = 0; k = 0;
    ah_o = '0; ah_e = '0; ale_ad = '0; ale_oe = 1'b0;
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    #1;
    while (cpu_stall && n_stall < 20) begin
      if (bus_ale) begin
        n_ale++; ale_ad = bus_ad_out; ale_oe = bus_ad_oe; ah_o = bus_ah_out; ah_e = bus_ah_oe;
        check(n_strb == 0, "R2 ale before strobe", n_strb, 0);
      end
      if (!bus_rd_n) begin n_strb++; bus_ad_in = base + 8'(k); k++; end
      if (!bus_wr_n) begin
        n_strb++;
        check(bus_ad_oe && bus_ad_out == wd, "R7 write data", {bus_ad_oe, bus_ad_out}, {1'b1, wd});
      end
      if (bus_rd_n && bus_wr_n && !bus_ale && n_strb > 0) n_hold++;
      n_stall++;
      @(negedge clk); #1;
    end
    check(n_ale == 1 && ale_ad == a[7:0] && ale_oe, "R2 address phase", {n_ale[7:0], ale_ad}, {8'd1, a[7:0]});
    check(n_strb == len, "R3 strobe length", n_strb, len);
    check(n_hold == hd, "R3 hold cycle", n_hold, hd);
    check(n_stall == 2 + len + hd, "R5 stall length", n_stall, 2 + len + hd);
    check(ah_e == exp_mask(v[4:1]) && ah_o == (a[15:8] & exp_mask(v[4:1])), "R9 high lines",
          {ah_e, ah_o}, {exp_mask(v[4:1]), a[15:8] & exp_mask(v[4:1])});
    if (!we) check(cpu_rdata == base + 8'(len - 1), "R6 read sample", cpu_rdata, base + 8'(len - 1));
    cpu_req = 1'b0;
    @(negedge clk); #1;
    check(bus_rd_n && bus_wr_n && !cpu_stall, "R8 idle strobes", {bus_rd_n, bus_wr_n, cpu_stall}, 3'b110);
    if (we && v[0]) check(bus_ad_hold && bus_ad_out == wd, "R10 keeper holds", {bus_ad_hold, bus_ad_out}, {1'b1, wd});
    if (!v[0]) check(!bus_ad_hold && bus_ad_out == 8'h00, "R10 keeper off", {bus_ad_hold, bus_ad_out}, 9'h0);
  endtask

  task automatic expect_ignored(input logic en, input logic [15:0] a, input string tag);
    bit seen;
    seen = 1'b0;
    cfg_en = en; cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = a;
    for (int i = 0; i < 4; i++) begin
      #1;
      if (cpu_stall || bus_ale || !bus_rd_n) seen = 1'b1;
      @(negedge clk);
    end
    check(!seen, tag, seen, 0);
    cpu_req = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    logic [7:0] held;
    repeat (3) @(negedge clk);
    #1;
    // R11 reset state
    check(bus_rd_n && bus_wr_n && !bus_ale && !bus_ad_oe && !cpu_stall && cpu_rdata == 8'h00,
          "R11 reset outputs", {bus_rd_n, bus_wr_n, bus_ale, bus_ad_oe, cpu_stall, cpu_rdata},
          {5'b11000, 8'h00});
    rst_n = 1'b1;
    @(negedge clk);

    // R1 disabled bus and internal boundary ignored
    expect_ignored(1'b0, 16'h8000, "R1 disabled ignored");
    expect_ignored(1'b1, 16'h025F, "R1 internal top ignored");
    expect_ignored(1'b1, 16'h0010, "R1 low internal ignored");
    #1;

    // table of accesses: R2 R3 R4 R5 R6 R7 R9 R10
    for (int i = 0; i < NV; i++) run_access(VEC[i]);

    // R6 read data held across a following write
    run_access({1'b0, 16'h3001, 8'h00, 2'd0, 2'd0, 3'd0, 4'd0, 1'b1});
    held = cpu_rdata;
    run_access({1'b1, 16'h3002, 8'h99, 2'd0, 2'd0, 3'd0, 4'd0, 1'b1});
    check(cpu_rdata == held, "R6 rdata held over write", cpu_rdata, held);

    // R4 boundary: top bits equal to limit selects upper setting
    run_access({1'b1, 16'h6000, 8'h11, 2'd0, 2'd2, 3'd3, 4'd0, 1'b0});
    run_access({1'b1, 16'h5FFF, 8'h22, 2'd0, 2'd2, 3'd3, 4'd0, 1'b0});

    // R9 disabled bus releases every high line
    cfg_en = 1'b0; cfg_hrel = 4'd0; #1;
    check(bus_ah_oe == 8'h00, "R9 lines off when disabled", bus_ah_oe, 8'h00);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule